// File: doc/BRIEF.md
# Quad-SPI PSRAM Bus Bridge

This block connects a slow, asynchronous 8-bit CPU strobe interface to a pseudo-static RAM that is reached over four serial data lines. It runs entirely on a fast internal clock. The CPU read and write strobes are brought into that clock domain, and each falling strobe is turned into one complete memory transaction. The transaction is short enough to finish inside a single half-period of the CPU clock, so the CPU never has to be stalled.

After reset the memory still expects single-line serial commands. The block therefore first sends a one-byte command on line 0 that switches the memory to four-line operation. From then on, every transfer moves one nibble per fast clock. A write sends a command, the address and the data byte. A read sends a command and the address, then releases the lines. It lets the memory's access latency pass and assembles the returned byte from two nibbles. That byte is held on the CPU read port for as long as the read strobe stays low.

The four data lines leave the block as separate output, output-enable and input vectors; the pad ring combines them into bidirectional pins. `mem_sck_o` is high in every cycle in which one bit or nibble is exchanged. The memory latches or presents data for that cycle, and the pad logic forms the serial clock from this signal and the fast clock.

Top module: `qpsram_bridge`

## Requirements
- R1: After reset, chip select stays high for the first cycle and is low for the next nine. The first of those nine cycles has no serial clock. In the other eight, `mem_sck_o` is high and line 0 alone is enabled, carrying 0x35 with bit 7 first. Chip select then returns high.
- R2: When a strobe is first seen low at clock edge k, the transaction's chip select goes low right after edge k+2. The strobe passes through two synchroniser flops and then one control register.
- R3: A write uses one setup cycle with chip select low and no serial clock. Ten cycles with `mem_sck_o` high follow, with all four lines enabled. They carry the 40-bit frame {0x38, the address zero-extended to 24 bits, write data}, most significant nibble first. Chip select rises right after the last nibble.
- R4: A read uses one setup cycle, then eight nibbles of {0xEB, 24-bit zero-extended address}, driven as in R3. It then holds RD_WAIT cycles (default 2) with the lines released and the serial clock running, and ignores the input in them. Two capture cycles follow, high nibble first. With the default, chip select is low for 13 cycles.
- R5: `cpu_rvalid_o` goes high right after the edge that captures the low nibble. It stays high until the third edge after the read strobe rises. While it is high, `cpu_rdata_o` shows the captured byte, and it shows 0x00 otherwise.
- R6: A strobe starts exactly one transaction however long it stays low. No new transaction starts until both strobes have been seen high again.
- R7: If both strobes are low when a transaction is accepted, a read is performed.
- R8: Outside a transaction and during reset, chip select is high, the serial clock is low and no line is enabled. The read port is 0x00 and not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_rd_ni | input | 1 | CPU read strobe, active low, asynchronous |
| cpu_wr_ni | input | 1 | CPU write strobe, active low, asynchronous |
| cpu_addr_i | input | ADDR_W | Byte address, stable while a strobe is low |
| cpu_wdata_i | input | 8 | Write data, stable while the write strobe is low |
| cpu_rdata_o | output | 8 | Read byte, 0x00 when not valid |
| cpu_rvalid_o | output | 1 | Read byte valid |
| mem_cs_no | output | 1 | Memory chip select, active low |
| mem_sck_o | output | 1 | Serial clock pulse marker, one per transferred bit or nibble |
| mem_sio_o | output | 4 | Data line output values |
| mem_sio_oe_o | output | 4 | Data line output enables |
| mem_sio_i | input | 4 | Data line input values |

## Verification
Every result has a fixed cycle offset from its cause. The quad-enable frame starts one edge after reset is released. Chip select falls three edges after the negative edge at which a strobe is lowered. Write nibbles follow at offsets 1 to 10 after that. Read nibbles follow at offsets 1 to 8, then the wait and capture cycles. The read byte becomes valid 13 edges after acceptance and is withdrawn three edges after the strobe rises. The bench turns each stimulus into a map of expected line states keyed by cycle number and compares the full line state and the read port at every falling edge. During the wait cycles the memory model drives values that differ from the real data, so a capture in the wrong cycle shows up on the read port.

// File: rtl/qpsram_pkg.sv
package qpsram_pkg;
  typedef enum logic [1:0] {
    ST_INIT,
    ST_IDLE,
    ST_SEND,
    ST_RECV
  } qp_state_e;

  localparam int unsigned SR_W     = 40;
  localparam int unsigned FIELD_W  = 24;
  localparam int unsigned NIB_RD   = 8;   // command + address
  localparam int unsigned NIB_WR   = 10;  // command + address + data
  localparam int unsigned INIT_BITS = 8;

  localparam logic [7:0] CMD_QUAD_ON = 8'h35;
  localparam logic [7:0] CMD_QREAD   = 8'hEB;
  localparam logic [7:0] CMD_QWRITE  = 8'h38;
endpackage

// File: rtl/qpsram_strobe_sync.sv
module qpsram_strobe_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  // strobes are active low: reset to the inactive level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '1;
    end else begin
      pipe_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/qpsram_ctrl.sv
module qpsram_ctrl
  import qpsram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 23,
  parameter int unsigned RD_WAIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_s_i,
  input  logic              wr_s_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              cs_no,
  output logic              sck_o,
  output logic [3:0]        sio_o,
  output logic [3:0]        sio_oe_o,
  output logic              cap_hi_o,
  output logic              cap_lo_o
);
  localparam int unsigned RX_LEN  = RD_WAIT + 2;
  localparam int unsigned CNT_MAX = (RX_LEN > NIB_WR) ? RX_LEN : NIB_WR;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [1:0]  LEAD_GAP   = 2'd2;
  localparam logic [1:0]  LEAD_SETUP = 2'd1;

  qp_state_e        state_q;
  logic [1:0]       lead_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SR_W-1:0]  sreg_q;
  logic             is_rd_q;
  logic             armed_q;

  logic             req;
  logic             take_rd;
  logic             shifting;
  logic [SR_W-1:0]  payload;

  assign take_rd = ~rd_s_i;
  assign req     = armed_q & (~rd_s_i | ~wr_s_i);

  always_comb begin
    if (take_rd) payload = {CMD_QREAD, FIELD_W'(addr_i), 8'h00};
    else         payload = {CMD_QWRITE, FIELD_W'(addr_i), wdata_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      lead_q  <= LEAD_GAP;
      cnt_q   <= CNT_W'(INIT_BITS - 1);
      sreg_q  <= {CMD_QUAD_ON, {(SR_W-8){1'b0}}};
      is_rd_q <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      if (rd_s_i && wr_s_i) armed_q <= 1'b1;
      unique case (state_q)
        ST_INIT: begin
          if (lead_q != 2'd0) begin
            lead_q <= lead_q - 2'd1;
          end else begin
            sreg_q <= {sreg_q[SR_W-2:0], 1'b0};
            cnt_q  <= cnt_q - CNT_W'(1);
            if (cnt_q == '0) state_q <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (req) begin
            state_q <= ST_SEND;
            lead_q  <= LEAD_SETUP;
            is_rd_q <= take_rd;
            sreg_q  <= payload;
            cnt_q   <= take_rd ? CNT_W'(NIB_RD - 1) : CNT_W'(NIB_WR - 1);
            armed_q <= 1'b0;
          end
        end
        ST_SEND: begin
          if (lead_q != 2'd0) begin
            lead_q <= 2'd0;
          end else begin
            sreg_q <= {sreg_q[SR_W-5:0], 4'h0};
            cnt_q  <= cnt_q - CNT_W'(1);
            if (cnt_q == '0) begin
              if (is_rd_q) begin
                state_q <= ST_RECV;
                cnt_q   <= CNT_W'(RX_LEN - 1);
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
        end
        ST_RECV: begin
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == '0) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign shifting = ((state_q == ST_INIT) || (state_q == ST_SEND)) && (lead_q == 2'd0);
  assign cs_no    = (state_q == ST_IDLE) || (lead_q == LEAD_GAP);
  assign sck_o    = shifting || (state_q == ST_RECV);
  assign cap_hi_o = (state_q == ST_RECV) && (cnt_q == CNT_W'(1));
  assign cap_lo_o = (state_q == ST_RECV) && (cnt_q == '0);

  always_comb begin
    sio_o    = 4'h0;
    sio_oe_o = 4'h0;
    if (shifting && state_q == ST_INIT) begin
      sio_o    = {3'b000, sreg_q[SR_W-1]};
      sio_oe_o = 4'b0001;
    end else if (shifting) begin
      sio_o    = sreg_q[SR_W-1 -: 4];
      sio_oe_o = 4'hF;
    end
  end

  assert_sck_within_cs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_no);
  assert_quiet_when_deselected_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (sio_oe_o == 4'h0));
  assert_lines_released_on_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_hi_o || cap_lo_o) |-> (sio_oe_o == 4'h0));
  assert_single_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_no) && $past(state_q) == ST_IDLE) |-> $past(armed_q));
  assert_read_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && armed_q && !rd_s_i) |=> is_rd_q);
endmodule

// File: rtl/qpsram_rxcap.sv
module qpsram_rxcap (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cap_hi_i,
  input  logic       cap_lo_i,
  input  logic       rd_s_i,
  input  logic [3:0] sio_i,
  output logic [7:0] rdata_o,
  output logic       rvalid_o
);
  logic [7:0] data_q;
  logic       valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= 8'h00;
      valid_q <= 1'b0;
    end else begin
      if (cap_hi_i) data_q[7:4] <= sio_i;
      if (cap_lo_i) begin
        data_q[3:0] <= sio_i;
        valid_q     <= 1'b1;
      end else if (rd_s_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign rdata_o  = valid_q ? data_q : 8'h00;
  assign rvalid_o = valid_q;

  assert_valid_after_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(cap_lo_i));
  assert_valid_drops_on_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && rd_s_i && !cap_lo_i) |=> !valid_q);
endmodule

// File: rtl/qpsram_bridge.sv
module qpsram_bridge #(
  parameter int unsigned ADDR_W      = 23,
  parameter int unsigned RD_WAIT     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_rd_ni,
  input  logic              cpu_wr_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [7:0]        cpu_wdata_i,
  output logic [7:0]        cpu_rdata_o,
  output logic              cpu_rvalid_o,
  output logic              mem_cs_no,
  output logic              mem_sck_o,
  output logic [3:0]        mem_sio_o,
  output logic [3:0]        mem_sio_oe_o,
  input  logic [3:0]        mem_sio_i
);
  logic [1:0] strb_s;
  logic       cap_hi;
  logic       cap_lo;

  qpsram_strobe_sync #(
    .WIDTH (2),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({cpu_rd_ni, cpu_wr_ni}),
    .sync_o (strb_s)
  );

  qpsram_ctrl #(
    .ADDR_W (ADDR_W),
    .RD_WAIT(RD_WAIT)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_s_i  (strb_s[1]),
    .wr_s_i  (strb_s[0]),
    .addr_i  (cpu_addr_i),
    .wdata_i (cpu_wdata_i),
    .cs_no   (mem_cs_no),
    .sck_o   (mem_sck_o),
    .sio_o   (mem_sio_o),
    .sio_oe_o(mem_sio_oe_o),
    .cap_hi_o(cap_hi),
    .cap_lo_o(cap_lo)
  );

  qpsram_rxcap u_rxcap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_hi_i(cap_hi),
    .cap_lo_i(cap_lo),
    .rd_s_i  (strb_s[1]),
    .sio_i   (mem_sio_i),
    .rdata_o (cpu_rdata_o),
    .rvalid_o(cpu_rvalid_o)
  );
endmodule

// File: tb/qpsram_bridge_tb_top.sv
module qpsram_bridge_tb_top;
  localparam int ADDR_W  = 23;
  localparam int RD_WAIT = 2;
  localparam int NEVER   = 1 << 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [22:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [3:0]  sio_in = '0;
  logic [7:0]  rdata;
  logic        rvalid;
  logic        cs_n;
  logic        sck;
  logic [3:0]  sio_out;
  logic [3:0]  sio_oe;

  qpsram_bridge #(.ADDR_W(ADDR_W), .RD_WAIT(RD_WAIT), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cpu_rd_ni(rd_n), .cpu_wr_ni(wr_n),
    .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .cpu_rvalid_o(rvalid),
    .mem_cs_no(cs_n), .mem_sck_o(sck), .mem_sio_o(sio_out), .mem_sio_oe_o(sio_oe),
    .mem_sio_i(sio_in)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // expected line state per cycle; absent entries mean idle
  bit         exp_cs_lo [int];
  bit         exp_sck   [int];
  logic [3:0] exp_oe    [int];
  logic [3:0] exp_sio   [int];
  string      exp_tag   [int];
  logic [3:0] drv       [int];
  logic [7:0] mem       [int];

  int         rv_from = NEVER;
  int         rv_to   = NEVER;
  logic [7:0] rv_data = 8'h00;

  function automatic logic [7:0] dflt(logic [22:0] a);
    return a[7:0] ^ a[22:15] ^ 8'h6C;
  endfunction

  task automatic put(int c, bit lo, bit k, logic [3:0] oe, logic [3:0] v, string tag);
    exp_cs_lo[c] = lo; exp_sck[c] = k; exp_oe[c] = oe; exp_sio[c] = v; exp_tag[c] = tag;
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit         e_lo, e_k, ok, e_v;
      logic [3:0] e_oe, e_sio;
      logic [7:0] e_d;
      string      tag;
      sio_in = drv.exists(cyc) ? drv[cyc] : 4'h0;
      e_lo  = exp_cs_lo.exists(cyc) ? exp_cs_lo[cyc] : 1'b0;
      e_k   = exp_sck.exists(cyc) ? exp_sck[cyc] : 1'b0;
      e_oe  = exp_oe.exists(cyc) ? exp_oe[cyc] : 4'h0;
      e_sio = exp_sio.exists(cyc) ? exp_sio[cyc] : 4'h0;
      tag   = exp_tag.exists(cyc) ? exp_tag[cyc] : "R8";
      ok = (cs_n == !e_lo) && (sck == e_k) && (sio_oe == e_oe) && ((sio_out & e_oe) == (e_sio & e_oe));
      n_cmp++;
      if (!ok) begin
        n_bad++;
        $display("FAIL %s cyc=%0d actual cs_n=%b sck=%b oe=%h sio=%h expected cs_n=%b sck=%b oe=%h sio=%h",
                 tag, cyc, cs_n, sck, sio_oe, sio_out & sio_oe, !e_lo, e_k, e_oe, e_sio & e_oe);
      end
      e_v = (cyc >= rv_from) && (cyc <= rv_to);
      e_d = e_v ? rv_data : 8'h00;
      n_cmp++;
      if (rvalid !== e_v || rdata !== e_d) begin
        n_bad++;
        $display("FAIL R5 cyc=%0d actual rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
                 cyc, rvalid, rdata, e_v, e_d);
      end
    end
  end

  task automatic wait_cyc(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // R1: quad-enable frame after reset
  task automatic sched_init(int r0);
    for (int i = 1; i <= 9; i++) put(r0 + i, 1'b1, 1'b0, 4'h0, 4'h0, "R1");
    for (int j = 0; j < 8; j++) put(r0 + 2 + j, 1'b1, 1'b1, 4'h1, {3'b000, 1'(8'h35 >> (7 - j))}, "R1");
  endtask

  // lowers strobes at the current negedge and schedules the expected frame
  task automatic start_txn(bit is_rd, bit both, logic [22:0] a, logic [7:0] d, output int e0);
    logic [39:0] pl;
    logic [7:0]  b;
    string       t;
    @(negedge clk);
    addr = a; wdata = d;
    if (is_rd || both) rd_n = 1'b0;
    if (!is_rd || both) wr_n = 1'b0;
    e0 = cyc + 3;
    t = both ? "R7" : (is_rd ? "R4" : "R3");
    pl = is_rd ? {8'hEB, 1'b0, a, 8'h00} : {8'h38, 1'b0, a, d};
    put(e0, 1'b1, 1'b0, 4'h0, 4'h0, "R2");
    if (is_rd) begin
      b = mem.exists(int'(a)) ? mem[int'(a)] : dflt(a);
      for (int j = 0; j < 8; j++) put(e0 + 1 + j, 1'b1, 1'b1, 4'hF, pl[39 - 4*j -: 4], t);
      for (int w = 0; w < RD_WAIT; w++) begin
        put(e0 + 9 + w, 1'b1, 1'b1, 4'h0, 4'h0, "R4");
        drv[e0 + 9 + w] = ~b[7:4] ^ 4'(w);  // junk that must be ignored
      end
      put(e0 + 9 + RD_WAIT, 1'b1, 1'b1, 4'h0, 4'h0, t);
      put(e0 + 10 + RD_WAIT, 1'b1, 1'b1, 4'h0, 4'h0, t);
      drv[e0 + 9 + RD_WAIT]  = b[7:4];
      drv[e0 + 10 + RD_WAIT] = b[3:0];
      rv_data = b;
      rv_to   = NEVER;
      rv_from = e0 + 11 + RD_WAIT;
    end else begin
      for (int j = 0; j < 10; j++) put(e0 + 1 + j, 1'b1, 1'b1, 4'hF, pl[39 - 4*j -: 4], t);
      mem[int'(a)] = d;
    end
  endtask

  task automatic do_write(logic [22:0] a, logic [7:0] d, int hold);
    int e0, rel;
    start_txn(1'b0, 1'b0, a, d, e0);
    rel = e0 - 2 + hold;
    if (hold > 12) for (int c = e0 + 11; c <= rel + 4; c++) exp_tag[c] = "R6";
    wait_cyc(rel);
    wr_n = 1'b1;
    wait_cyc((rel + 3 > e0 + 12) ? rel + 3 : e0 + 12);
  endtask

  task automatic do_read(logic [22:0] a, bit both, int hold);
    int e0, rel;
    start_txn(1'b1, both, a, 8'h00, e0);
    rel = e0 + 11 + RD_WAIT + hold;
    if (hold > 4) for (int c = e0 + 13 + RD_WAIT; c <= rel + 4; c++) exp_tag[c] = "R6";
    wait_cyc(rel);
    rd_n = 1'b1; wr_n = 1'b1;
    rv_to = cyc + 2;
    wait_cyc(rel + 3);
  endtask

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    r0 = cyc;
    sched_init(r0);
    wait_cyc(r0 + 13);
    do_write(23'h000123, 8'h5A, 0);        // R3 shortest strobe
    do_read(23'h000123, 1'b0, 1);          // R4, R5
    do_write(23'h7FFFFF, 8'hC3, 3);        // R3 top address
    do_read(23'h7FFFFF, 1'b0, 0);          // R4
    do_read(23'h000000, 1'b0, 2);          // R4 unwritten location
    do_write(23'h2AAAAA, 8'h96, 24);       // R6 long write strobe
    do_read(23'h2AAAAA, 1'b1, 1);          // R7 both strobes low
    do_read(23'h155555, 1'b0, 12);         // R6 long read strobe
    do_write(23'h155555, 8'h0F, 1);
    do_read(23'h155555, 1'b0, 0);
    wait_cyc(cyc + 8);                     // R8 idle
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog cyc=%0d actual running expected finished", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule